// File: doc/BRIEF.md
# Accumulator ALU Datapath with Flags

This block is the arithmetic core of a small accumulator machine. It keeps an accumulator A, a second register B and three status flags (zero, signed overflow, carry). On each clock where the execute enable is high, a packed 11-bit command word selects an ALU function, the second operand, flag clears and an optional load of B. The block performs that operation in one cycle.

The second operand comes from one of four places: memory read data, an immediate value, register B, or the constant one. The immediate path can also carry a program counter value into A. An equality output compares A with B so that a sequencer can use it for branches. Instruction fetch, memory and branching are outside this block. The data width is a parameter and defaults to 8 bits.

Top module: `acc_datapath`

## Requirements
- R1: While `rst_n` is low, A, B, Z, OV and C are all zero, and they stay zero until the first executed command.
- R2: The operand select `cmd[1:0]` picks the second operand: 00 memory data, 01 immediate, 10 register B, 11 the constant one. Op `cmd[5:2]`=0000 stores A+operand in A, and 0001 stores A-operand in A, both modulo 2^W.
- R3: On add, C takes the carry out. On subtract, C takes the inverted borrow, so it is 1 when A >= operand unsigned. On both, OV is set exactly on two's-complement overflow. Other ops leave OV unchanged.
- R4: Op 0100 is AND, 0101 is OR, 0110 is XOR (each with the operand), 1100 is bitwise NOT of A, 1001 is two's-complement negate of A, and 1101 clears A to zero.
- R5: Op 0111 shifts A right and keeps the MSB. Op 1000 keeps the MSB, moves bits W-3..0 up one place and puts 0 in the LSB. Op 1010 shifts toward the MSB with a zero fill, and 1011 shifts toward the LSB with a zero fill.
- R6: Op 1110 rotates right through C: the new MSB is the old C and the new C is the old bit 0. Op 1111 rotates left through C: the new LSB is the old C and the new C is the old MSB.
- R7: Op 0011 copies the selected operand into A. Op 0010 leaves A and all flags unchanged, apart from explicit clears.
- R8: Every op other than 0010 writes A and sets Z to 1 exactly when the new A is zero.
- R9: The clear field `cmd[8:6]` clears C with bit 8, OV with bit 7 and Z with bit 6. A clear wins over a flag update in the same cycle.
- R10: The B-load field `cmd[10:9]` loads B from the immediate value when it is 01 and from memory data when it is 11. With 00 or 10, B keeps its value. Any operand read from B uses the value B held before the edge.
- R11: When `exec` is low, A, B and the flags keep their values whatever the command.
- R12: `equal` is high exactly when A equals B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec | input | 1 | Execute the command on this edge |
| cmd | input | 11 | Command: B-load, flag clear, ALU op, operand select |
| mem_data | input | W | Memory read data |
| imm | input | W | Immediate operand or PC value |
| acc | output | W | Accumulator A |
| breg | output | W | Register B |
| flag_z | output | 1 | Zero flag |
| flag_ov | output | 1 | Signed overflow flag |
| flag_c | output | 1 | Carry flag |
| equal | output | 1 | A equals B |

## Verification
Directed cases first hit the arithmetic edges. These are 0x7F+1, which tells signed overflow apart from carry, and equal-operand subtraction, which tells the zero and no-borrow results apart from the borrow case. Directed cases also cover sign-keeping shifts on values with differing top bits, which separate the arithmetic and logical shifts. Rotates run with C both set and clear, so they can be told apart from plain shifts. A clear is issued in the same cycle as a flag-setting add, and a hold command and a disabled cycle are applied, to show clear priority and the no-effect paths. Several hundred random commands then mix all ops, operand sources, B loads and clear patterns, and an independent bench model checks every output after each one.

// File: rtl/acc_dp_pkg.sv
`timescale 1ns/1ps
package acc_dp_pkg;
  localparam int CMD_W  = 11;
  localparam int CLR_C  = 2;
  localparam int CLR_OV = 1;
  localparam int CLR_Z  = 0;

  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000, OP_SUB = 4'b0001, OP_HOLD = 4'b0010, OP_PASS = 4'b0011,
    OP_AND  = 4'b0100, OP_OR  = 4'b0101, OP_XOR  = 4'b0110, OP_ASR  = 4'b0111,
    OP_ASL  = 4'b1000, OP_NEG = 4'b1001, OP_SHL  = 4'b1010, OP_SHR  = 4'b1011,
    OP_NOT  = 4'b1100, OP_CLR = 4'b1101, OP_RRC  = 4'b1110, OP_RLC  = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {SRC_MEM = 2'b00, SRC_IMM = 2'b01, SRC_B = 2'b10, SRC_ONE = 2'b11} opnd_sel_e;
  typedef enum logic [1:0] {BLD_HOLD = 2'b00, BLD_IMM = 2'b01, BLD_RSVD = 2'b10, BLD_MEM = 2'b11} bld_sel_e;

  typedef struct packed {
    bld_sel_e  bld;
    logic [2:0] clr;
    alu_op_e   op;
    opnd_sel_e src;
  } cmd_t;
endpackage

// File: rtl/acc_dp_opsel.sv
`timescale 1ns/1ps
module acc_dp_opsel
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  opnd_sel_e    sel,
  input  logic [W-1:0] mem_data,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] b_val,
  output logic [W-1:0] opnd
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (sel)
      SRC_MEM: opnd = mem_data;
      SRC_IMM: opnd = imm;
      SRC_B:   opnd = b_val;
      default: opnd = ONE;
    endcase
  end
endmodule

// File: rtl/acc_dp_alu.sv
`timescale 1ns/1ps
module acc_dp_alu
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         wr_a,
  output logic         c_upd,
  output logic         c_nxt,
  output logic         ov_upd,
  output logic         ov_nxt
);
  localparam int MSB = W - 1;

  logic [W:0] sum;
  logic [W:0] dif;

  assign sum = {1'b0, a} + {1'b0, b};
  assign dif = {1'b0, a} - {1'b0, b};

  always_comb begin
    res    = a;
    wr_a   = 1'b1;
    c_upd  = 1'b0;
    c_nxt  = c_in;
    ov_upd = 1'b0;
    ov_nxt = 1'b0;
    case (op)
      OP_ADD: begin
        res    = sum[W-1:0];
        c_upd  = 1'b1;
        c_nxt  = sum[W];
        ov_upd = 1'b1;
        ov_nxt = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
      end
      OP_SUB: begin
        res    = dif[W-1:0];
        c_upd  = 1'b1;
        c_nxt  = ~dif[W];
        ov_upd = 1'b1;
        ov_nxt = (a[MSB] != b[MSB]) && (dif[MSB] != a[MSB]);
      end
      OP_HOLD: wr_a = 1'b0;
      OP_PASS: res = b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_ASR:  res = {a[MSB], a[MSB:1]};
      OP_ASL:  res = {a[MSB], a[MSB-2:0], 1'b0};
      OP_NEG:  res = (~a) + W'(1);
      OP_SHL:  res = {a[MSB-1:0], 1'b0};
      OP_SHR:  res = {1'b0, a[MSB:1]};
      OP_NOT:  res = ~a;
      OP_CLR:  res = '0;
      OP_RRC: begin
        res   = {c_in, a[MSB:1]};
        c_upd = 1'b1;
        c_nxt = a[0];
      end
      default: begin
        res   = {a[MSB-1:0], c_in};
        c_upd = 1'b1;
        c_nxt = a[MSB];
      end
    endcase
  end
endmodule

// File: rtl/acc_dp_flags.sv
`timescale 1ns/1ps
module acc_dp_flags
  import acc_dp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] clr,
  input  logic       wr_a,
  input  logic       res_zero,
  input  logic       c_upd,
  input  logic       c_val,
  input  logic       ov_upd,
  input  logic       ov_val,
  output logic       z_q,
  output logic       ov_q,
  output logic       c_q
);
  logic z_d, ov_d, c_d;

  always_comb begin
    z_d  = z_q;
    ov_d = ov_q;
    c_d  = c_q;
    if (en) begin
      if (wr_a)   z_d  = res_zero;
      if (ov_upd) ov_d = ov_val;
      if (c_upd)  c_d  = c_val;
      if (clr[CLR_Z])  z_d  = 1'b0;
      if (clr[CLR_OV]) ov_d = 1'b0;
      if (clr[CLR_C])  c_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      z_q  <= 1'b0;
      ov_q <= 1'b0;
      c_q  <= 1'b0;
    end else begin
      z_q  <= z_d;
      ov_q <= ov_d;
      c_q  <= c_d;
    end
  end

  p_clear_c_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr[CLR_C]) |=> !c_q);
  p_clear_z_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr[CLR_Z]) |=> !z_q);
  p_clear_ov_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && clr[CLR_OV]) |=> !ov_q);
endmodule

// File: rtl/acc_datapath.sv
`timescale 1ns/1ps
module acc_datapath
  import acc_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         exec,
  input  logic [10:0]  cmd,
  input  logic [W-1:0] mem_data,
  input  logic [W-1:0] imm,
  output logic [W-1:0] acc,
  output logic [W-1:0] breg,
  output logic         flag_z,
  output logic         flag_ov,
  output logic         flag_c,
  output logic         equal
);
  cmd_t         cw;
  logic [W-1:0] opnd, res, a_d, b_d, a_q, b_q;
  logic         wr_a, c_upd, c_nxt, ov_upd, ov_nxt;

  assign cw = cmd_t'(cmd);

  acc_dp_opsel #(.W(W)) u_opsel (
    .sel(cw.src), .mem_data(mem_data), .imm(imm), .b_val(b_q), .opnd(opnd)
  );

  acc_dp_alu #(.W(W)) u_alu (
    .op(cw.op), .a(a_q), .b(opnd), .c_in(flag_c), .res(res), .wr_a(wr_a),
    .c_upd(c_upd), .c_nxt(c_nxt), .ov_upd(ov_upd), .ov_nxt(ov_nxt)
  );

  acc_dp_flags u_flags (
    .clk(clk), .rst_n(rst_n), .en(exec), .clr(cw.clr), .wr_a(wr_a),
    .res_zero(res == '0), .c_upd(c_upd), .c_val(c_nxt), .ov_upd(ov_upd),
    .ov_val(ov_nxt), .z_q(flag_z), .ov_q(flag_ov), .c_q(flag_c)
  );

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    if (exec) begin
      if (wr_a) a_d = res;
      case (cw.bld)
        BLD_IMM: b_d = imm;
        BLD_MEM: b_d = mem_data;
        default: b_d = b_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  assign acc   = a_q;
  assign breg  = b_q;
  assign equal = (a_q == b_q);

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(acc) && $stable(breg) && $stable(flag_z) && $stable(flag_ov) && $stable(flag_c)));
  p_op_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cw.op == OP_HOLD && cw.clr == 3'b000) |=> ($stable(acc) && $stable(flag_z) && $stable(flag_ov) && $stable(flag_c)));
  p_b_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !cw.bld[0]) |=> $stable(breg));
  p_clear_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cw.op == OP_CLR && !cw.clr[CLR_Z]) |=> (acc == '0 && flag_z));
endmodule

// File: tb/sim_acc_datapath.sv
`timescale 1ns/1ps
module sim_acc_datapath;
  logic        clk = 1'b0;
  logic        rst_n, exec;
  logic [10:0] cmd;
  logic [7:0]  mem_data, imm, acc, breg;
  logic        flag_z, flag_ov, flag_c, equal;
  int total = 0, bad = 0;
  bit done = 0;
  logic [7:0] ma, mb;
  logic mz, mov, mc;

  always #10 clk = ~clk;

  acc_datapath #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .exec(exec), .cmd(cmd), .mem_data(mem_data),
    .imm(imm), .acc(acc), .breg(breg), .flag_z(flag_z), .flag_ov(flag_ov),
    .flag_c(flag_c), .equal(equal)
  );

  function automatic logic [10:0] mk(input logic [1:0] bl, input logic [2:0] cl,
                                     input logic [3:0] op, input logic [1:0] sl);
    return {bl, cl, op, sl};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000, 4'b0001: return "R2/R3";
      4'b0010, 4'b0011: return "R7";
      4'b0111, 4'b1000, 4'b1010, 4'b1011: return "R5";
      4'b1110, 4'b1111: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic model(input logic [10:0] c, input logic [7:0] md, input logic [7:0] im);
    logic [7:0] o, r;
    logic [8:0] t;
    logic wr, nc, nov;
    case (c[1:0])
      2'b00: o = md;
      2'b01: o = im;
      2'b10: o = mb;
      default: o = 8'd1;
    endcase
    r = ma; wr = 1'b1; nc = mc; nov = mov;
    case (c[5:2])
      4'b0000: begin t = ma + o; r = t[7:0]; nc = t[8];
               nov = (ma[7] == o[7]) && (r[7] != ma[7]); end
      4'b0001: begin r = ma - o; nc = (ma >= o);
               nov = (ma[7] != o[7]) && (r[7] != ma[7]); end
      4'b0010: wr = 1'b0;
      4'b0011: r = o;
      4'b0100: r = ma & o;
      4'b0101: r = ma | o;
      4'b0110: r = ma ^ o;
      4'b0111: r = {ma[7], ma[7:1]};
      4'b1000: r = {ma[7], ma[5:0], 1'b0};
      4'b1001: r = 8'd0 - ma;
      4'b1010: r = ma << 1;
      4'b1011: r = ma >> 1;
      4'b1100: r = ~ma;
      4'b1101: r = 8'd0;
      4'b1110: begin r = {mc, ma[7:1]}; nc = ma[0]; end
      default: begin r = {ma[6:0], mc}; nc = ma[7]; end
    endcase
    if (c[10:9] == 2'b01) mb = im;
    else if (c[10:9] == 2'b11) mb = md;
    if (wr) begin ma = r; mz = (r == 8'd0); end
    mc = nc; mov = nov;
    if (c[8]) mc = 1'b0;
    if (c[7]) mov = 1'b0;
    if (c[6]) mz = 1'b0;
  endtask

  task automatic check(input string tag);
    total++;
    if (acc !== ma || breg !== mb || flag_z !== mz || flag_ov !== mov ||
        flag_c !== mc || equal !== (ma == mb)) begin
      bad++;
      $display("FAIL %s: got A=%h B=%h Z=%b OV=%b C=%b EQ=%b, expected A=%h B=%h Z=%b OV=%b C=%b EQ=%b",
               tag, acc, breg, flag_z, flag_ov, flag_c, equal,
               ma, mb, mz, mov, mc, (ma == mb));
    end
  endtask

  // drive at a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic ex, input logic [10:0] c, input logic [7:0] md,
                      input logic [7:0] im, input string tag);
    @(negedge clk);
    exec = ex; cmd = c; mem_data = md; imm = im;
    if (ex) model(c, md, im);
    @(negedge clk);
    check(tag);
    exec = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20250917));
    rst_n = 1'b0; exec = 1'b0; cmd = '0; mem_data = '0; imm = '0;
    ma = '0; mb = '0; mz = 0; mov = 0; mc = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1'b1;
    step(1'b0, mk(2'b01, 3'b000, 4'b0011, 2'b01), 8'h44, 8'h55, "R1");
    step(1'b1, mk(2'b00, 3'b000, 4'b0011, 2'b01), 8'h00, 8'h7F, "R7");
    step(1'b1, mk(2'b01, 3'b000, 4'b0010, 2'b00), 8'h00, 8'h01, "R10");
    step(1'b1, mk(2'b00, 3'b000, 4'b0000, 2'b10), 8'h00, 8'h00, "R3");
    step(1'b1, mk(2'b00, 3'b000, 4'b0000, 2'b11), 8'h00, 8'h00, "R2");
    step(1'b1, mk(2'b00, 3'b000, 4'b0011, 2'b00), 8'h05, 8'h00, "R7");
    step(1'b1, mk(2'b00, 3'b000, 4'b0001, 2'b01), 8'h00, 8'h05, "R8");
    step(1'b1, mk(2'b00, 3'b000, 4'b0001, 2'b11), 8'h00, 8'h00, "R3");
    step(1'b1, mk(2'b00, 3'b000, 4'b0011, 2'b01), 8'h00, 8'hC1, "R7");
    step(1'b1, mk(2'b00, 3'b000, 4'b1000, 2'b00), 8'h00, 8'h00, "R5");
    step(1'b1, mk(2'b00, 3'b000, 4'b0111, 2'b00), 8'h00, 8'h00, "R5");
    step(1'b1, mk(2'b00, 3'b000, 4'b1010, 2'b00), 8'h00, 8'h00, "R5");
    step(1'b1, mk(2'b00, 3'b000, 4'b1011, 2'b00), 8'h00, 8'h00, "R5");
    step(1'b1, mk(2'b00, 3'b000, 4'b1110, 2'b00), 8'h00, 8'h00, "R6");
    step(1'b1, mk(2'b00, 3'b000, 4'b1111, 2'b00), 8'h00, 8'h00, "R6");
    step(1'b1, mk(2'b00, 3'b000, 4'b0011, 2'b01), 8'h00, 8'hFF, "R7");
    step(1'b1, mk(2'b00, 3'b111, 4'b0000, 2'b11), 8'h00, 8'h00, "R9");
    step(1'b1, mk(2'b00, 3'b000, 4'b0001, 2'b01), 8'h00, 8'h01, "R3");
    step(1'b1, mk(2'b00, 3'b000, 4'b1110, 2'b00), 8'h00, 8'h00, "R6");
    step(1'b0, mk(2'b11, 3'b111, 4'b1101, 2'b00), 8'h9A, 8'h00, "R11");
    step(1'b1, mk(2'b10, 3'b000, 4'b0010, 2'b00), 8'h9A, 8'h9A, "R7");
    step(1'b1, mk(2'b11, 3'b000, 4'b0011, 2'b00), 8'h3C, 8'h00, "R12");
    step(1'b1, mk(2'b00, 3'b000, 4'b1001, 2'b00), 8'h00, 8'h00, "R4");
    step(1'b1, mk(2'b00, 3'b000, 4'b1101, 2'b00), 8'h00, 8'h00, "R4");
    step(1'b1, mk(2'b00, 3'b000, 4'b1100, 2'b00), 8'h00, 8'h00, "R4");
    for (int i = 0; i < 600; i++) begin
      logic [10:0] c;
      logic ex;
      c = 11'($urandom);
      if ($urandom_range(3) != 0) c[8:6] = 3'b000;
      ex = ($urandom_range(7) != 0);
      step(ex, c, 8'($urandom), 8'($urandom), ex ? tag_of(c[5:2]) : "R11");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got no end, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule